// File: doc/BRIEF.md
# Checkpoint-Ordered Watchdog

This block is a watchdog for a security subsystem. It catches two kinds of software fault. The first is software that stops servicing the watchdog in time. The second is software that passes its checkpoints in the wrong order.

Software programs three things through a register-write port: a timeout limit, an ordered list of checkpoint identifiers, and the number of entries in that list. It then reports progress by writing checkpoint identifiers to a dedicated address. A checkpoint that matches the next expected entry restarts the timeout counter. A checkpoint that does not match raises a mismatch event. Once a lock write has been made, the configuration can no longer change until reset.

The write port uses a valid/ready handshake. The block never applies back-pressure, so `wr_ready` stays high and a write is taken on every clock edge where `wr_valid` is high. The event flags and the alarm are plain level and pulse outputs.

Top module: `chkpt_watchdog`

## Requirements
- R1: After reset, `timeout_evt`, `mismatch_evt` and `alarm` are low, and `wr_ready` is high.
- R2: An upward-only 16-bit counter advances once per clock. When it reaches the programmed timeout limit (address 1, data[15:0]) with no valid checkpoint in between, `timeout_evt` goes high on the following edge.
- R3: A checkpoint write (address 0, identifier in data[7:0]) that matches the expected entry clears the counter to zero. A correct checkpoint given at intervals shorter than the limit therefore prevents the timeout.
- R4: Each correct checkpoint advances the expected-entry pointer. After the last entry of the programmed length, the pointer wraps to entry 0.
- R5: A checkpoint whose identifier differs from the expected entry sets `mismatch_evt`. It neither clears the counter nor advances the pointer.
- R6: Both event flags are sticky: once set, each stays high until reset.
- R7: `alarm` is high for exactly one cycle, in the cycle after either event flag rises. If both flags rise together, only one pulse is produced.
- R8: A write to address 3 with data[0]=1 sets a lock. After that, writes to the timeout, length and sequence registers have no effect until reset.
- R9: Sequence entry k is written at address 8+k (data[7:0]). The length register (address 2) takes data[2:0] as length minus one, so the length ranges from 1 to 8.
- R10: Reset values are a timeout limit of 1000, a length of 1, and all sequence entries 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Write accepted; always high |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Write data |
| timeout_evt | output | 1 | Sticky timeout event flag |
| mismatch_evt | output | 1 | Sticky checkpoint-order event flag |
| alarm | output | 1 | One-cycle pulse when either flag rises |

## Verification
The hardest situation to reach from the ports is showing that a wrong checkpoint leaves the counter running, because the counter itself is not visible. The stimulus services the watchdog and lets most of a short window pass. It then sends a wrong identifier and waits for the rest of the window; the timeout must still arrive on schedule. Lock effects are shown the same way. After locking, a new timeout limit and a new sequence entry are written. A checkpoint carrying the old identifier must then be accepted, and the timeout must fire at the old limit.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CNT_W     = 16;
  localparam int ID_W      = 8;
  localparam int SEQ_DEPTH = 8;
  localparam int PTR_W     = $clog2(SEQ_DEPTH);
  localparam int ADDR_W    = PTR_W + 1;
  localparam logic [CNT_W-1:0] TMO_RESET = CNT_W'(1000);

  typedef enum logic [ADDR_W-1:0] {
    A_CHKPT = ADDR_W'(0),
    A_TMO   = ADDR_W'(1),
    A_LEN   = ADDR_W'(2),
    A_LOCK  = ADDR_W'(3)
  } reg_addr_e;
endpackage

// File: rtl/wdt_cfg_regs.sv
module wdt_cfg_regs
  import wdt_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_fire,
  input  logic [ADDR_W-1:0]                 wr_addr,
  input  logic [CNT_W-1:0]                  wr_data,
  output logic [CNT_W-1:0]                  tmo_lim,
  output logic [PTR_W-1:0]                  len_m1,
  output logic [SEQ_DEPTH-1:0][ID_W-1:0]    seq_tab,
  output logic                              locked
);
  logic cfg_we;
  assign cfg_we = wr_fire && !locked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmo_lim <= TMO_RESET;
      len_m1  <= '0;
      locked  <= 1'b0;
    end else begin
      if (cfg_we && wr_addr == A_TMO) tmo_lim <= wr_data;
      if (cfg_we && wr_addr == A_LEN) len_m1  <= wr_data[PTR_W-1:0];
      if (wr_fire && wr_addr == A_LOCK && wr_data[0]) locked <= 1'b1;
    end
  end

  for (genvar k = 0; k < SEQ_DEPTH; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) seq_tab[k] <= '0;
      else if (cfg_we && wr_addr[ADDR_W-1] && wr_addr[PTR_W-1:0] == PTR_W'(k))
        seq_tab[k] <= wr_data[ID_W-1:0];
    end
  end
endmodule

// File: rtl/wdt_seq_check.sv
module wdt_seq_check
  import wdt_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cp_valid,
  input  logic [ID_W-1:0]                cp_id,
  input  logic [PTR_W-1:0]               len_m1,
  input  logic [SEQ_DEPTH-1:0][ID_W-1:0] seq_tab,
  output logic                           kick,
  output logic                           mismatch
);
  logic [PTR_W-1:0] ptr;
  logic             hit;

  assign hit  = (cp_id == seq_tab[ptr]);
  assign kick = cp_valid && hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr      <= '0;
      mismatch <= 1'b0;
    end else if (cp_valid) begin
      if (hit) ptr <= (ptr >= len_m1) ? '0 : ptr + 1'b1;
      else     mismatch <= 1'b1;
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kick,
  input  logic [CNT_W-1:0] tmo_lim,
  output logic [CNT_W-1:0] cnt,
  output logic             expired
);
  logic at_lim;
  assign at_lim = (cnt >= tmo_lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else begin
      if (kick)        cnt <= '0;
      else if (!at_lim) cnt <= cnt + 1'b1;
      if (at_lim && !kick) expired <= 1'b1;
    end
  end
endmodule

// File: rtl/wdt_event.sv
module wdt_event (
  input  logic clk,
  input  logic rst_n,
  input  logic tmo_flag,
  input  logic mm_flag,
  output logic alarm
);
  logic tmo_d, mm_d, pulse;
  assign pulse = (tmo_flag && !tmo_d) || (mm_flag && !mm_d);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmo_d <= 1'b0;
      mm_d  <= 1'b0;
      alarm <= 1'b0;
    end else begin
      tmo_d <= tmo_flag;
      mm_d  <= mm_flag;
      alarm <= pulse;
    end
  end
endmodule

// File: rtl/chkpt_watchdog.sv
module chkpt_watchdog
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic              timeout_evt,
  output logic              mismatch_evt,
  output logic              alarm
);
  logic                           wr_fire, cp_valid, kick;
  logic [CNT_W-1:0]               tmo_lim, cnt;
  logic [PTR_W-1:0]               len_m1;
  logic [SEQ_DEPTH-1:0][ID_W-1:0] seq_tab;
  logic                           locked;

  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid && wr_ready;
  assign cp_valid = wr_fire && wr_addr == A_CHKPT;

  wdt_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_addr(wr_addr),
    .wr_data(wr_data), .tmo_lim(tmo_lim), .len_m1(len_m1),
    .seq_tab(seq_tab), .locked(locked)
  );

  wdt_seq_check u_seq (
    .clk(clk), .rst_n(rst_n), .cp_valid(cp_valid),
    .cp_id(wr_data[ID_W-1:0]), .len_m1(len_m1), .seq_tab(seq_tab),
    .kick(kick), .mismatch(mismatch_evt)
  );

  wdt_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .kick(kick), .tmo_lim(tmo_lim),
    .cnt(cnt), .expired(timeout_evt)
  );

  wdt_event u_evt (
    .clk(clk), .rst_n(rst_n), .tmo_flag(timeout_evt),
    .mm_flag(mismatch_evt), .alarm(alarm)
  );
endmodule

// File: rtl/chkpt_watchdog_sva.sv
module chkpt_watchdog_sva
  import wdt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] tmo_lim,
  input logic             locked,
  input logic             timeout_evt,
  input logic             mismatch_evt,
  input logic             alarm
);
  p_cnt_upward_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != 0 |-> cnt == $past(cnt) + 1'b1 || cnt == $past(cnt));

  p_tmo_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> timeout_evt);

  p_mm_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch_evt |=> mismatch_evt);

  p_alarm_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    alarm |=> !alarm);

  p_alarm_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_evt) |=> alarm);

  p_lock_tmo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    locked && wr_valid && wr_addr == A_TMO |=> $stable(tmo_lim));
endmodule

bind chkpt_watchdog chkpt_watchdog_sva u_sva (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .cnt(cnt), .tmo_lim(tmo_lim), .locked(locked),
  .timeout_evt(timeout_evt), .mismatch_evt(mismatch_evt), .alarm(alarm)
);

// File: tb/chkpt_watchdog_bench.sv
module chkpt_watchdog_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        timeout_evt, mismatch_evt, alarm;

  int checks = 0;
  int fails  = 0;
  int alarm_cnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chkpt_watchdog u_chkpt_watchdog (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .timeout_evt(timeout_evt),
    .mismatch_evt(mismatch_evt), .alarm(alarm)
  );

  always @(negedge clk) if (rst_n && alarm) alarm_cnt++;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_valid = 1'b0;
    wait_cyc(2);
    rst_n = 1'b1;
    alarm_cnt = 0;
  endtask

  task automatic wr(int a, int d);
    wr_valid = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    wait_cyc(1);
    check("R1 timeout_evt", timeout_evt, 0);
    check("R1 mismatch_evt", mismatch_evt, 0);
    check("R1 alarm", alarm, 0);
    check("R1 wr_ready", wr_ready, 1);
  endtask

  task automatic t_timeout();
    do_reset();
    wr(1, 20);
    wr(0, 0);                       // R10: entry 0 resets to 0, length 1
    wait_cyc(17);
    check("R2 no early timeout", timeout_evt, 0);
    wait_cyc(6);
    check("R2 timeout raised", timeout_evt, 1);
    check("R7 one alarm pulse", alarm_cnt, 1);
    wait_cyc(30);
    check("R6 timeout sticky", timeout_evt, 1);
    check("R7 no extra pulse", alarm_cnt, 1);
  endtask

  task automatic t_service();
    do_reset();
    wr(1, 20);
    for (int i = 0; i < 6; i++) begin
      wr(0, 0);
      wait_cyc(14);
    end
    check("R3 serviced no timeout", timeout_evt, 0);
    check("R3 no mismatch", mismatch_evt, 0);
  endtask

  task automatic t_sequence();
    do_reset();
    wr(8, 'hA1); wr(9, 'hB2); wr(10, 'hC3);
    wr(2, 2);                       // R9: length 3
    wr(0, 'hA1); wr(0, 'hB2); wr(0, 'hC3);
    wr(0, 'hA1); wr(0, 'hB2); wr(0, 'hC3); wr(0, 'hA1);
    wait_cyc(2);
    check("R4 ordered with wrap", mismatch_evt, 0);
    wr(0, 'hA1);                    // expected B2
    wait_cyc(2);
    check("R5 mismatch raised", mismatch_evt, 1);
    check("R7 mismatch alarm", alarm_cnt, 1);
    check("R5 no timeout yet", timeout_evt, 0);
  endtask

  task automatic t_length2();
    do_reset();
    wr(8, 'h11); wr(9, 'h22); wr(10, 'h33);
    wr(2, 1);                       // R9: length 2, so 11 follows 22
    wr(0, 'h11); wr(0, 'h22); wr(0, 'h11);
    wait_cyc(1);
    check("R4 wrap after length 2", mismatch_evt, 0);
  endtask

  task automatic t_wrong_no_clear();
    do_reset();
    wr(1, 30);
    wr(0, 0);
    wait_cyc(18);
    wr(0, 'h55);                    // wrong id
    wait_cyc(15);
    check("R5 counter not cleared", timeout_evt, 1);
    check("R6 mismatch sticky", mismatch_evt, 1);
    check("R7 two pulses", alarm_cnt, 2);
  endtask

  task automatic t_lock();
    do_reset();
    wr(8, 'h10);
    wr(1, 20);
    wr(3, 1);
    wr(1, 900); wr(8, 'h77); wr(2, 3);
    wr(0, 'h10);
    wr(0, 'h10);                    // length still 1
    wait_cyc(1);
    check("R8 sequence locked", mismatch_evt, 0);
    wait_cyc(25);
    check("R8 timeout locked", timeout_evt, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_timeout();
    t_service();
    t_sequence();
    t_length2();
    t_wrong_no_clear();
    t_lock();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule